// File: doc/BRIEF.md
# Multi-mode 8-bit waveform timer

This block is an 8-bit counter that advances once per cycle of a timer clock enable. A three-bit mode field picks one of three counting schemes. In free-running mode the counter only counts up. In clear-on-compare (CTC) mode channel A's compare value sets the period. In phase-correct PWM mode the counter runs up to full scale and back down to zero.

Two compare channels, A and B, each hold a compare value and a two-bit action field. Each channel drives one waveform pin and sets a sticky hit flag when the count matches its compare value. A third sticky flag records overflow. Flags are cleared by a write-one strobe or by an acknowledge input. A bus write to the count can happen at any time, and it overrides counting in the same cycle. The prescaler, the clock-domain crossing and the pin multiplexing are left to the surrounding logic.

Top module: `wavetmr8`

## Requirements
- R1: In free-running mode (mode code 0) the count rises by one on each cycle with `tick` high and wraps from 0xFF to 0x00. With `tick` low the count holds in every mode. After reset the count, the compare values, the pins and all flags are 0.
- R2: The overflow flag (flag bit 0) sets on the same edge at which the count goes from 0xFF to 0x00 in free-running or CTC mode, or down-counts to 0x00 in PWM mode. A CTC clear at the compare value does not set it.
- R3: In CTC mode (mode code 2), a tick while the count equals compare A loads 0x00, so the count never passes compare A.
- R4: If compare A is written below the current count in CTC mode, the match is missed. The count runs on to 0xFF, wraps to 0x00 with an overflow, and only then clears at compare A.
- R5: A channel's hit flag (bit 1 for A, bit 2 for B) sets on the tick edge that leaves a count equal to that channel's compare value.
- R6: A count write (`cnt_we`) loads `cnt_wdata` whether or not `tick` is high. In that cycle no count step, no hit and no overflow takes place.
- R7: Outside PWM mode, a hit applies the channel's action to its pin: 0 hold, 1 toggle, 2 drive low, 3 drive high.
- R8: Outside PWM mode, a force strobe applies the channel's action to its pin at once, and it does not set the hit flag. In PWM mode force strobes have no effect.
- R9: A one on `flag_w1c` or `flag_ack` clears the matching flag bit (0 overflow, 1 hit A, 2 hit B). A set event in the same cycle wins, and the other flags are left unchanged.
- R10: In PWM mode (mode code 1) the count turns from counting up to counting down at 0xFF (0xFF is followed by 0xFE), and turns back up at 0x00.
- R11: In PWM mode, action 2 (non-inverted) drives the pin low on an up-count hit and high on a down-count hit. Action 3 gives the opposite levels. With action 2, a compare value of 0x00 keeps the pin low and 0xFF keeps it high; action 3 gives the reverse.
- R12: In PWM mode the tick at count 0x00 forces the pin to the level it should have at the start of the up phase (high for action 2 when the compare value is not 0). This happens even when no match has occurred, for example after the count was loaded below the compare value while counting down.
- R13: Outside PWM mode, a compare write takes effect on the next edge. In PWM mode the write goes into a holding stage, and the active compare value takes that stage on the tick at 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable; low stops counting |
| wave_mode | input | 3 | 0 free-running, 1 phase-correct PWM, 2 CTC; other codes act as 0 |
| act_a | input | 2 | Channel A pin action field |
| act_b | input | 2 | Channel B pin action field |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | CW | Count write value |
| cmp_a_we | input | 1 | Compare A write strobe |
| cmp_b_we | input | 1 | Compare B write strobe |
| cmp_wdata | input | CW | Compare write value (shared) |
| force_a | input | 1 | Channel A force strobe |
| force_b | input | 1 | Channel B force strobe |
| flag_w1c | input | 3 | Write-one-to-clear flag strobes |
| flag_ack | input | 3 | Interrupt-acknowledge flag clears |
| count | output | CW | Current count |
| cmp_a | output | CW | Active compare A value |
| cmp_b | output | CW | Active compare B value |
| pin_a | output | 1 | Channel A waveform pin |
| pin_b | output | 1 | Channel B waveform pin |
| ovf_flag | output | 1 | Overflow flag |
| hit_a_flag | output | 1 | Channel A hit flag |
| hit_b_flag | output | 1 | Channel B hit flag |

## Verification
The properties assume that every input is a clean 0 or 1 from the first edge after reset. They also assume that `wave_mode` and the action fields are sampled on the same edge as the tick they qualify, so a mode change counts from the edge at which it is seen. The stimulus changes inputs only on the falling clock edge and switches modes only while `tick` is low or between whole test phases. Compare values in PWM are loaded while the block is outside PWM mode whenever a phase needs a known starting value.

// File: rtl/wavetmr8_pkg.sv
package wavetmr8_pkg;

  typedef enum logic [2:0] {
    WM_NORMAL = 3'd0,
    WM_PWM_PC = 3'd1,
    WM_CTC    = 3'd2
  } wmode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } act_e;

  localparam int NCH   = 2;
  localparam int NFLAG = NCH + 1;

  function automatic logic act_apply(input logic [1:0] act, input logic cur);
    case (act_e'(act))
      ACT_TOGGLE: return ~cur;
      ACT_CLEAR:  return 1'b0;
      ACT_SET:    return 1'b1;
      default:    return cur;
    endcase
  endfunction

  function automatic logic is_pwm(input logic [2:0] m);
    return m == WM_PWM_PC;
  endfunction

  function automatic logic is_ctc(input logic [2:0] m);
    return m == WM_CTC;
  endfunction

  // level of a PWM pin given inversion and the "high" sense
  function automatic logic pwm_level(input logic inv, input logic high);
    return inv ^ high;
  endfunction

endpackage

// File: rtl/wavetmr8_flag.sv
module wavetmr8_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= set_i | (flag_o & ~clr_i);
  end

endmodule

// File: rtl/wavetmr8_count.sv
module wavetmr8_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          pwm,
  input  logic          ctc,
  input  logic [CW-1:0] ctc_top,
  output logic [CW-1:0] count,
  output logic          dn_next,
  output logic          ovf_evt,
  output logic          top_evt,
  output logic          bot_evt
);

  localparam logic [CW-1:0] MAXV = {CW{1'b1}};
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic          dn_q;
  logic [CW-1:0] nxt;

  function automatic logic [CW-1:0] step_val(input logic [CW-1:0] c,
                                             input logic p, input logic k,
                                             input logic d,
                                             input logic [CW-1:0] t);
    if (p) return d ? c - ONE : c + ONE;
    if (k && c == t) return '0;
    return c + ONE;
  endfunction

  // direction used by this step: turn at the two ends
  always_comb begin
    if (!pwm)               dn_next = 1'b0;
    else if (count == MAXV) dn_next = 1'b1;
    else if (count == '0)   dn_next = 1'b0;
    else                    dn_next = dn_q;
  end

  assign nxt     = step_val(count, pwm, ctc, dn_next, ctc_top);
  assign ovf_evt = step_en && (nxt == '0) && (!ctc || count == MAXV);
  assign top_evt = step_en && pwm && (count == MAXV);
  assign bot_evt = step_en && pwm && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      dn_q  <= 1'b0;
    end else begin
      if (load)         count <= load_val;
      else if (step_en) count <= nxt;
      if (step_en)      dn_q  <= dn_next;
    end
  end

endmodule

// File: rtl/wavetmr8_chan.sv
module wavetmr8_chan
  import wavetmr8_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          pwm,
  input  logic          top_evt,
  input  logic          bot_evt,
  input  logic          dn_next,
  input  logic [CW-1:0] count,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  input  logic [1:0]    act,
  input  logic          force_i,
  output logic [CW-1:0] ocr,
  output logic          pin,
  output logic          hit_evt
);

  logic [CW-1:0] stage_q;
  logic          pin_nxt;
  logic          pwm_drive;
  logic          pwm_inv;

  assign hit_evt   = step_en && (count == ocr);
  assign pwm_drive = act[1];
  assign pwm_inv   = (act == 2'b11);

  always_comb begin
    pin_nxt = pin;
    if (!pwm) begin
      if (hit_evt || force_i) pin_nxt = act_apply(act, pin);
    end else if (pwm_drive) begin
      if (bot_evt)      pin_nxt = pwm_level(pwm_inv, ocr != '0);
      else if (hit_evt) pin_nxt = pwm_level(pwm_inv, dn_next);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      ocr     <= '0;
      pin     <= 1'b0;
    end else begin
      if (we) stage_q <= wdata;
      if (we && !pwm)   ocr <= wdata;
      else if (top_evt) ocr <= stage_q;
      pin <= pin_nxt;
    end
  end

endmodule

// File: rtl/wavetmr8.sv
module wavetmr8
  import wavetmr8_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [2:0]       wave_mode,
  input  logic [1:0]       act_a,
  input  logic [1:0]       act_b,
  input  logic             cnt_we,
  input  logic [CW-1:0]    cnt_wdata,
  input  logic             cmp_a_we,
  input  logic             cmp_b_we,
  input  logic [CW-1:0]    cmp_wdata,
  input  logic             force_a,
  input  logic             force_b,
  input  logic [NFLAG-1:0] flag_w1c,
  input  logic [NFLAG-1:0] flag_ack,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    cmp_a,
  output logic [CW-1:0]    cmp_b,
  output logic             pin_a,
  output logic             pin_b,
  output logic             ovf_flag,
  output logic             hit_a_flag,
  output logic             hit_b_flag
);

  // named internal events (observed by the checker)
  logic             step_en;
  logic             pwm_m;
  logic             ctc_m;
  logic             ovf_evt;
  logic             top_evt;
  logic             bot_evt;
  logic             dn_next;
  logic [NCH-1:0]   hit_v;
  logic [NCH-1:0]   we_v;
  logic [NCH-1:0]   force_v;
  logic [NCH-1:0]   pin_v;
  logic [1:0]       act_v [NCH];
  logic [CW-1:0]    ocr_v [NCH];
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] flag_v;

  assign step_en = tick & ~cnt_we;
  assign pwm_m   = is_pwm(wave_mode);
  assign ctc_m   = is_ctc(wave_mode);

  assign we_v     = {cmp_b_we, cmp_a_we};
  assign force_v  = {force_b, force_a};
  assign act_v[0] = act_a;
  assign act_v[1] = act_b;

  wavetmr8_count #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .load     (cnt_we),
    .load_val (cnt_wdata),
    .pwm      (pwm_m),
    .ctc      (ctc_m),
    .ctc_top  (ocr_v[0]),
    .count    (count),
    .dn_next  (dn_next),
    .ovf_evt  (ovf_evt),
    .top_evt  (top_evt),
    .bot_evt  (bot_evt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wavetmr8_chan #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (step_en),
      .pwm     (pwm_m),
      .top_evt (top_evt),
      .bot_evt (bot_evt),
      .dn_next (dn_next),
      .count   (count),
      .we      (we_v[i]),
      .wdata   (cmp_wdata),
      .act     (act_v[i]),
      .force_i (force_v[i] & ~pwm_m),
      .ocr     (ocr_v[i]),
      .pin     (pin_v[i]),
      .hit_evt (hit_v[i])
    );
  end

  assign set_v = {hit_v, ovf_evt};

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    wavetmr8_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[f]),
      .clr_i  (flag_w1c[f] | flag_ack[f]),
      .flag_o (flag_v[f])
    );
  end

  assign cmp_a      = ocr_v[0];
  assign cmp_b      = ocr_v[1];
  assign pin_a      = pin_v[0];
  assign pin_b      = pin_v[1];
  assign ovf_flag   = flag_v[0];
  assign hit_a_flag = flag_v[1];
  assign hit_b_flag = flag_v[2];

endmodule

// File: rtl/wavetmr8_chk.sv
module wavetmr8_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cnt_we,
  input logic [CW-1:0] cnt_wdata,
  input logic [2:0]    wave_mode,
  input logic [CW-1:0] count,
  input logic [CW-1:0] cmp_a,
  input logic          cmp_a_we,
  input logic [CW-1:0] cmp_wdata,
  input logic          force_a,
  input logic [2:0]    flag_w1c,
  input logic          ovf_flag,
  input logic          hit_a_flag,
  input logic          ovf_evt,
  input logic          hit_a_evt
);

  localparam logic [CW-1:0] MAXV = {CW{1'b1}};
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count == $past(cnt_wdata));

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(count));

  a_r1_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == 3'd0 && tick && !cnt_we) |=> count == $past(count) + ONE);

  a_r2_wrap_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == 3'd0 && tick && !cnt_we && count == MAXV) |=> (ovf_flag && count == '0));

  a_r3_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == 3'd2 && tick && !cnt_we && count == cmp_a) |=> count == '0);

  a_r5_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && count == cmp_a) |=> hit_a_flag);

  a_r8_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (force_a && !hit_a_flag && !hit_a_evt) |=> !hit_a_flag);

  a_r9_w1c_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w1c[0] && !ovf_evt) |=> !ovf_flag);

  a_r10_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == 3'd1 && tick && !cnt_we && count == MAXV) |=> count == MAXV - ONE);

  a_r13_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode != 3'd1 && cmp_a_we) |=> cmp_a == $past(cmp_wdata));

endmodule

bind wavetmr8 wavetmr8_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .cnt_we     (cnt_we),
  .cnt_wdata  (cnt_wdata),
  .wave_mode  (wave_mode),
  .count      (count),
  .cmp_a      (cmp_a),
  .cmp_a_we   (cmp_a_we),
  .cmp_wdata  (cmp_wdata),
  .force_a    (force_a),
  .flag_w1c   (flag_w1c),
  .ovf_flag   (ovf_flag),
  .hit_a_flag (hit_a_flag),
  .ovf_evt    (ovf_evt),
  .hit_a_evt  (hit_v[0])
);

// File: tb/wavetmr8_bench.sv
module wavetmr8_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] wave_mode = 3'd0;
  logic [1:0] act_a = 2'd0;
  logic [1:0] act_b = 2'd0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = 8'd0;
  logic       cmp_a_we = 1'b0;
  logic       cmp_b_we = 1'b0;
  logic [7:0] cmp_wdata = 8'd0;
  logic       force_a = 1'b0;
  logic       force_b = 1'b0;
  logic [2:0] flag_w1c = 3'd0;
  logic [2:0] flag_ack = 3'd0;
  logic [7:0] count, cmp_a, cmp_b;
  logic       pin_a, pin_b, ovf_flag, hit_a_flag, hit_b_flag;

  wavetmr8 u_wavetmr8 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wave_mode(wave_mode),
    .act_a(act_a), .act_b(act_b), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmp_a_we(cmp_a_we), .cmp_b_we(cmp_b_we), .cmp_wdata(cmp_wdata),
    .force_a(force_a), .force_b(force_b), .flag_w1c(flag_w1c), .flag_ack(flag_ack),
    .count(count), .cmp_a(cmp_a), .cmp_b(cmp_b), .pin_a(pin_a), .pin_b(pin_b),
    .ovf_flag(ovf_flag), .hit_a_flag(hit_a_flag), .hit_b_flag(hit_b_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_dn;
  int m_ocr [2];
  int m_stg [2];
  int m_pin [2];
  int m_flag [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dn = 0;
      for (int i = 0; i < 2; i++) begin m_ocr[i] = 0; m_stg[i] = 0; m_pin[i] = 0; end
      for (int k = 0; k < 3; k++) m_flag[k] = 0;
    end else begin
      int c, nd, nc, step, pwm, ctc, inv;
      int hit [2];
      int fset [3];
      int act [2];
      int we [2];
      int frc [2];
      int wd;
      c = m_cnt; step = tick && !cnt_we;
      pwm = (wave_mode == 3'd1); ctc = (wave_mode == 3'd2);
      act[0] = int'(act_a); act[1] = int'(act_b);
      we[0] = cmp_a_we; we[1] = cmp_b_we;
      frc[0] = force_a; frc[1] = force_b;
      wd = int'(cmp_wdata);
      nd = 0;
      if (pwm) nd = (c == 255) ? 1 : (c == 0) ? 0 : m_dn;
      if (pwm) nc = nd ? c - 1 : c + 1;
      else if (ctc && c == m_ocr[0]) nc = 0;
      else nc = (c + 1) % 256;
      fset[0] = step && nc == 0 && (!ctc || c == 255);
      for (int i = 0; i < 2; i++) begin
        hit[i] = step && (c == m_ocr[i]);
        fset[i+1] = hit[i];
        if (!pwm) begin
          if (hit[i] || frc[i])
            case (act[i])
              1: m_pin[i] = !m_pin[i];
              2: m_pin[i] = 0;
              3: m_pin[i] = 1;
              default: ;
            endcase
        end else if (act[i] >= 2) begin
          inv = (act[i] == 3);
          if (step && c == 0) m_pin[i] = inv ^ (m_ocr[i] != 0);
          else if (hit[i])    m_pin[i] = inv ^ nd;
        end
        if (we[i] && !pwm) m_ocr[i] = wd;
        else if (step && pwm && c == 255) m_ocr[i] = m_stg[i];
        if (we[i]) m_stg[i] = wd;
      end
      m_cnt = cnt_we ? int'(cnt_wdata) : step ? nc : c;
      if (step) m_dn = nd;
      m_flag[0] = fset[0] || (m_flag[0] && !(flag_w1c[0] || flag_ack[0]));
      m_flag[1] = fset[1] || (m_flag[1] && !(flag_w1c[1] || flag_ack[1]));
      m_flag[2] = fset[2] || (m_flag[2] && !(flag_w1c[2] || flag_ack[2]));
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 count", int'(count), m_cnt);
      check("R13 cmp_a", int'(cmp_a), m_ocr[0]);
      check("R13 cmp_b", int'(cmp_b), m_ocr[1]);
      check(wave_mode == 3'd1 ? "R11 pin_a" : "R7 pin_a", int'(pin_a), m_pin[0]);
      check(wave_mode == 3'd1 ? "R11 pin_b" : "R7 pin_b", int'(pin_b), m_pin[1]);
      check("R2 ovf_flag", int'(ovf_flag), m_flag[0]);
      check("R5 hit_a_flag", int'(hit_a_flag), m_flag[1]);
      check("R5 hit_b_flag", int'(hit_b_flag), m_flag[2]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cnt(input int v);
    cnt_we = 1'b1; cnt_wdata = v[7:0];
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic wr_cmp(input int ch, input int v);
    cmp_wdata = v[7:0];
    if (ch == 0) cmp_a_we = 1'b1; else cmp_b_we = 1'b1;
    @(negedge clk);
    cmp_a_we = 1'b0; cmp_b_we = 1'b0;
  endtask

  task automatic w1c(input int mask);
    flag_w1c = mask[2:0];
    @(negedge clk);
    flag_w1c = 3'd0;
  endtask

  task automatic ack(input int mask);
    flag_ack = mask[2:0];
    @(negedge clk);
    flag_ack = 3'd0;
  endtask

  task automatic wait_count(input int v);
    int g;
    g = 0;
    while (int'(count) != v && g < 3000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    int mx, hi_a, lo_b, saw_turn, prev;
    idle(3);
    // reset state (R1)
    check("R1 reset count", int'(count), 0);
    check("R1 reset ovf", int'(ovf_flag), 0);
    check("R1 reset hit_a", int'(hit_a_flag), 0);
    check("R1 reset pin_a", int'(pin_a), 0);
    rst_n = 1'b1;

    // free-running mode with toggle on A, set on B (R1, R7)
    wave_mode = 3'd0; act_a = 2'd1; act_b = 2'd3;
    wr_cmp(0, 5);
    wr_cmp(1, 3);
    tick = 1'b1;
    idle(10);
    check("R7 set on hit B", int'(pin_b), 1);
    check("R7 toggle on hit A", int'(pin_a), 1);
    wr_cnt(8'hF0);
    check("R6 count load while ticking", int'(count), 8'hF0);
    idle(20);
    check("R2 overflow after wrap", int'(ovf_flag), 1);
    check("R1 count after wrap", int'(count), 4);
    tick = 1'b0;
    w1c(3'b001);
    check("R9 w1c clears overflow", int'(ovf_flag), 0);
    ack(3'b010);
    check("R9 ack clears hit A", int'(hit_a_flag), 0);
    check("R9 other flag untouched", int'(hit_b_flag), 1);
    idle(5);
    check("R1 stopped count holds", int'(count), 4);
    wr_cnt(8'h33);
    check("R6 write while stopped", int'(count), 8'h33);

    // force strobes (R8)
    w1c(3'b100);
    act_b = 2'd2; force_b = 1'b1; @(negedge clk); force_b = 1'b0;
    check("R8 force clear B", int'(pin_b), 0);
    act_b = 2'd3; force_b = 1'b1; @(negedge clk); force_b = 1'b0;
    check("R8 force set B", int'(pin_b), 1);
    check("R8 force leaves flag", int'(hit_b_flag), 0);
    force_a = 1'b1; @(negedge clk); force_a = 1'b0;
    check("R8 force toggle A", int'(pin_a), 0);

    // write priority over a pending hit (R6)
    wr_cnt(5);
    tick = 1'b1;
    wr_cnt(5);
    check("R6 write beats step", int'(count), 5);
    check("R6 write suppresses hit", int'(hit_a_flag), 0);

    // CTC (R3, R2)
    tick = 1'b0;
    wave_mode = 3'd2;
    wr_cmp(0, 10);
    wr_cnt(0);
    w1c(3'b111);
    tick = 1'b1;
    mx = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
    end
    check("R3 CTC peak equals compare A", mx, 10);
    check("R2 no overflow on CTC clear", int'(ovf_flag), 0);

    // missed compare in CTC (R4)
    tick = 1'b0;
    wr_cnt(20);
    tick = 1'b1;
    mx = 0;
    for (int n = 0; n < 260; n++) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
    end
    check("R4 missed match runs to 0xFF", mx, 255);
    check("R4 wrap sets overflow", int'(ovf_flag), 1);
    check("R4 clears after wrap", int'(count) <= 10, 1);

    // phase-correct PWM, extremes (R10, R11)
    tick = 1'b0;
    wave_mode = 3'd0;
    wr_cmp(0, 0);
    wr_cmp(1, 255);
    wr_cnt(0);
    act_a = 2'd2; act_b = 2'd2;
    wave_mode = 3'd1;
    tick = 1'b1;
    idle(600);
    hi_a = 0; lo_b = 0; saw_turn = 0; prev = int'(count);
    for (int n = 0; n < 520; n++) begin
      @(negedge clk);
      if (pin_a) hi_a++;
      if (!pin_b) lo_b++;
      if (prev == 255 && int'(count) == 254) saw_turn = 1;
      prev = int'(count);
    end
    check("R10 turn at top", saw_turn, 1);
    check("R11 compare 0 stays low", hi_a, 0);
    check("R11 compare 0xFF stays high", lo_b, 0);
    act_b = 2'd3;
    idle(520);
    check("R11 inverted 0xFF stays low", int'(pin_b), 0);

    // buffered compare (R13)
    wait_count(8'h10);
    wr_cmp(0, 8'h40);
    check("R13 PWM write held", int'(cmp_a), 0);
    wait_count(8'hFF);
    idle(1);
    check("R13 PWM update at top", int'(cmp_a), 8'h40);

    // forced level at BOTTOM without a match (R12)
    wait_count(8'hF0);
    wr_cnt(8'h20);
    wait_count(0);
    check("R12 low before bottom", int'(pin_a), 0);
    idle(1);
    check("R12 high after bottom", int'(pin_a), 1);

    finish_run();
  end

endmodule